// File: doc/BRIEF.md
# Reconfigurable FSM Property Monitor

This block is a runtime checker placed beside functional logic. It watches a few probed signals and reports misbehaviour. Its main engine is a small state machine. The per-state compare masks, compare values, next states and violation markings of that machine are data held in registers, not fixed gates. Four fixed predicates sit beside it:
- an address window check on bus accesses,
- a must-stay-low signal check,
- an output-change check while a core's clock enable is low,
- a responder-identity check.

Configuration is written into a shadow copy through a simple write port. A commit strobe moves the shadow copy into the active copy in a single edge, so the monitor can be reprogrammed while the checks keep running. Each check sets its own bit in a sticky status register. Software clears these bits by writing ones. A one-cycle pulse marks the first detection after the status register was empty. Until the first commit the monitor is blank and reports nothing.

Top module: `fsm_prop_monitor`

## Requirements
- R1: Every probe-side input is registered once before use. In state S, if `(probe_q & mask[S]) == cmp[S]`, the next state is entry bits [2:0], otherwise it is bits [5:3]. The machine only advances while enable bit 0 is set.
- R2: A `cfg_commit` pulse copies the whole shadow configuration into the active one and forces `fsm_state` to 0 on the same edge.
- R3: After reset and before the first commit, `status` stays 0 whatever the probes do.
- R4: Configuration writes change only the shadow copy. Active checking is unaffected until the next commit.
- R5: With enable bit 0 set, being in a state whose entry bit 6 is 1 sets `status[0]`.
- R6: With enable bit 1 set, a registered bus access with `lo <= addr <= hi` (inclusive) sets `status[1]`.
- R7: With enable bit 2 set, a registered high level on `quiet_sig` sets `status[2]`.
- R8: With enable bit 3 set, a registered `core_out` that differs from its previous registered value while registered `core_clk_en` is 0 sets `status[3]`. A change while the enable is 1 does not.
- R9: With enable bit 4 set, a registered response whose `rsp_id` differs from the configured own ID (control bits [11:8]) sets `status[4]`.
- R10: Status bits are sticky. A `clr_we` write clears the bits set in `clr_data`, but a hit in the same cycle wins. `viol_flag` is the OR of the status bits.
- R11: `viol_pulse` is high for one cycle when a hit occurs while `status` is 0.
- R12: Configuration address map: `{bank,idx}`. Bank 0 holds transition entries, bank 1 masks, bank 2 compare values. Bank 3 has index 0 = range low, index 1 = range high, index 2 = control (bits [4:0] enables, [11:8] own ID).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Shadow configuration write strobe |
| cfg_addr | input | 5 | Configuration address {bank, index} |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_commit | input | 1 | Swap shadow into active, reset state machine |
| clr_we | input | 1 | Status clear strobe |
| clr_data | input | 5 | Write-one-to-clear mask for status |
| probe | input | 16 | Probed signals for the state machine |
| bus_valid | input | 1 | Bus access valid |
| bus_addr | input | 16 | Bus access address |
| quiet_sig | input | 1 | Signal required to stay low |
| core_clk_en | input | 1 | Watched core clock enable |
| core_out | input | 8 | Watched core outputs |
| rsp_valid | input | 1 | Response valid |
| rsp_id | input | 4 | Identity of the responding core |
| viol_pulse | output | 1 | One-cycle first-detection pulse |
| viol_flag | output | 1 | Any sticky violation pending |
| status | output | 5 | Sticky per-check violation bits |
| fsm_state | output | 3 | Current state of the programmable machine |

## Verification
The programmable machine is driven with three probe patterns:
- a full matching sequence with masked-off bits that differ, which must reach the violation state;
- a sequence that matches the first step and misses the second, which must fall back through the default branch;
- a commit issued mid-sequence, which must discard progress.

The address window is probed just below, at and just above its limits, which separates inclusive from exclusive compares. The gating check sees a change with the enable high, a steady value with it low, and a change with it low. These three cases tell a real gated change from a missing or inverted enable term. A behavioural model in the bench follows every cycle.

// File: rtl/fsm_prop_monitor.sv
module fsm_prop_monitor #(
  parameter int PW  = 16,
  parameter int NS  = 8,
  parameter int AW  = 16,
  parameter int OW  = 8,
  parameter int IDW = 4,
  localparam int SW  = $clog2(NS),
  localparam int CAW = SW + 2,
  localparam int NCK = 5,
  localparam int TW  = 2 * SW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [PW-1:0]  cfg_wdata,
  input  logic           cfg_commit,
  input  logic           clr_we,
  input  logic [NCK-1:0] clr_data,
  input  logic [PW-1:0]  probe,
  input  logic           bus_valid,
  input  logic [AW-1:0]  bus_addr,
  input  logic           quiet_sig,
  input  logic           core_clk_en,
  input  logic [OW-1:0]  core_out,
  input  logic           rsp_valid,
  input  logic [IDW-1:0] rsp_id,
  output logic           viol_pulse,
  output logic           viol_flag,
  output logic [NCK-1:0] status,
  output logic [SW-1:0]  fsm_state
);

  logic [PW-1:0]  sh_mask [NS], sh_cmp [NS], ac_mask [NS], ac_cmp [NS];
  logic [TW-1:0]  sh_tr [NS], ac_tr [NS];
  logic [AW-1:0]  sh_lo, sh_hi, ac_lo, ac_hi;
  logic [NCK-1:0] sh_en, ac_en;
  logic [IDW-1:0] sh_id, ac_id;
  logic           armed;

  logic [PW-1:0]  p_probe;
  logic           p_bv, p_quiet, p_cen, p_rv;
  logic [AW-1:0]  p_addr;
  logic [OW-1:0]  p_out, p_out_d;
  logic [IDW-1:0] p_rid;

  wire [1:0]    bank = cfg_addr[CAW-1 -: 2];
  wire [SW-1:0] idx  = cfg_addr[SW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        sh_mask[i] <= '0; sh_cmp[i] <= '0; sh_tr[i] <= '0;
      end
      sh_lo <= '0; sh_hi <= '0; sh_en <= '0; sh_id <= '0;
    end else if (cfg_we) begin
      case (bank)
        2'd0: sh_tr[idx]   <= cfg_wdata[TW-1:0];
        2'd1: sh_mask[idx] <= cfg_wdata;
        2'd2: sh_cmp[idx]  <= cfg_wdata;
        default:
          if (idx == SW'(0))      sh_lo <= cfg_wdata[AW-1:0];
          else if (idx == SW'(1)) sh_hi <= cfg_wdata[AW-1:0];
          else if (idx == SW'(2)) begin
            sh_en <= cfg_wdata[NCK-1:0];
            sh_id <= cfg_wdata[8 +: IDW];
          end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        ac_mask[i] <= '0; ac_cmp[i] <= '0; ac_tr[i] <= '0;
      end
      ac_lo <= '0; ac_hi <= '0; ac_en <= '0; ac_id <= '0; armed <= 1'b0;
    end else if (cfg_commit) begin
      for (int i = 0; i < NS; i++) begin
        ac_mask[i] <= sh_mask[i]; ac_cmp[i] <= sh_cmp[i]; ac_tr[i] <= sh_tr[i];
      end
      ac_lo <= sh_lo; ac_hi <= sh_hi; ac_en <= sh_en; ac_id <= sh_id; armed <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_probe <= '0; p_bv <= 1'b0; p_addr <= '0; p_quiet <= 1'b0;
      p_cen <= 1'b0; p_out <= '0; p_out_d <= '0; p_rv <= 1'b0; p_rid <= '0;
    end else begin
      p_probe <= probe; p_bv <= bus_valid; p_addr <= bus_addr; p_quiet <= quiet_sig;
      p_cen <= core_clk_en; p_out <= core_out; p_out_d <= p_out;
      p_rv <= rsp_valid; p_rid <= rsp_id;
    end

  wire [TW-1:0] ent   = ac_tr[fsm_state];
  wire          match = (p_probe & ac_mask[fsm_state]) == ac_cmp[fsm_state];
  wire [SW-1:0] nx    = match ? ent[SW-1:0] : ent[2*SW-1:SW];

  logic [NCK-1:0] raw, hits;
  assign raw[0] = ac_en[0] & ent[2*SW];
  assign raw[1] = ac_en[1] & p_bv & (p_addr >= ac_lo) & (p_addr <= ac_hi);
  assign raw[2] = ac_en[2] & p_quiet;
  assign raw[3] = ac_en[3] & ~p_cen & (p_out != p_out_d);
  assign raw[4] = ac_en[4] & p_rv & (p_rid != ac_id);
  assign hits   = armed ? raw : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     fsm_state <= '0;
    else if (cfg_commit)            fsm_state <= '0;
    else if (armed && ac_en[0])     fsm_state <= nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status     <= '0;
      viol_pulse <= 1'b0;
    end else begin
      status     <= (status & ~(clr_we ? clr_data : '0)) | hits;
      viol_pulse <= (|hits) && (status == '0);
    end

  assign viol_flag = |status;

  a_r3_blank_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> status == '0);
  a_r2_commit_state0: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> fsm_state == '0);
  a_r4_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(ac_en) && $stable(ac_lo) && $stable(ac_hi) && $stable(ac_id));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (status & $past(status)) == $past(status));
  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |=> !viol_pulse);
  a_r11_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> $countones(status) > 0);

endmodule

// File: tb/fsm_prop_monitor_test.sv
`timescale 1ns/1ps
module fsm_prop_monitor_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_commit = 0, clr_we = 0;
  logic [4:0] cfg_addr = 0, clr_data = 0;
  logic [15:0] cfg_wdata = 0, probe = 0, bus_addr = 0;
  logic bus_valid = 0, quiet_sig = 0, core_clk_en = 1, rsp_valid = 0;
  logic [7:0] core_out = 0;
  logic [3:0] rsp_id = 0;
  logic viol_pulse, viol_flag;
  logic [4:0] status;
  logic [2:0] fsm_state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fsm_prop_monitor uut (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_commit,
    .clr_we, .clr_data, .probe, .bus_valid, .bus_addr, .quiet_sig, .core_clk_en,
    .core_out, .rsp_valid, .rsp_id, .viol_pulse, .viol_flag, .status, .fsm_state);

  // behavioural reference model
  int s_tr[8], s_mask[8], s_cmp[8], a_tr[8], a_mask[8], a_cmp[8];
  int s_lo, s_hi, s_en, s_id, a_lo, a_hi, a_en, a_id;
  bit armed;
  int m_state, m_status, m_pulse;
  int q_probe, q_bv, q_addr, q_quiet, q_cen, q_out, q_outd, q_rv, q_rid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (s_tr[i]) begin s_tr[i]=0; s_mask[i]=0; s_cmp[i]=0; a_tr[i]=0; a_mask[i]=0; a_cmp[i]=0; end
      {s_lo,s_hi,s_en,s_id,a_lo,a_hi,a_en,a_id} = '0;
      armed = 0; m_state = 0; m_status = 0; m_pulse = 0;
      {q_probe,q_bv,q_addr,q_quiet,q_cen,q_out,q_outd,q_rv,q_rid} = '0;
    end else begin
      int hits, nxt;
      hits = 0;
      if (armed) begin
        if ((a_en & 1) && (a_tr[m_state] & 64)) hits |= 1;
        if ((a_en & 2) && q_bv && q_addr >= a_lo && q_addr <= a_hi) hits |= 2;
        if ((a_en & 4) && q_quiet) hits |= 4;
        if ((a_en & 8) && !q_cen && q_out != q_outd) hits |= 8;
        if ((a_en & 16) && q_rv && q_rid != a_id) hits |= 16;
      end
      nxt = ((q_probe & a_mask[m_state]) == a_cmp[m_state]) ? (a_tr[m_state] & 7) : ((a_tr[m_state] >> 3) & 7);
      m_pulse = (hits != 0 && m_status == 0);
      m_status = (m_status & ~(clr_we ? int'(clr_data) : 0)) | hits;
      if (cfg_commit) m_state = 0;
      else if (armed && (a_en & 1)) m_state = nxt;
      if (cfg_commit) begin
        a_tr = s_tr; a_mask = s_mask; a_cmp = s_cmp;
        a_lo = s_lo; a_hi = s_hi; a_en = s_en; a_id = s_id; armed = 1;
      end
      if (cfg_we) begin
        case (cfg_addr[4:3])
          0: s_tr[cfg_addr[2:0]] = cfg_wdata & 127;
          1: s_mask[cfg_addr[2:0]] = cfg_wdata;
          2: s_cmp[cfg_addr[2:0]] = cfg_wdata;
          3: case (cfg_addr[2:0])
               0: s_lo = cfg_wdata;
               1: s_hi = cfg_wdata;
               2: begin s_en = cfg_wdata & 31; s_id = (cfg_wdata >> 8) & 15; end
               default: ;
             endcase
        endcase
      end
      q_outd = q_out;
      q_probe = probe; q_bv = bus_valid; q_addr = bus_addr; q_quiet = quiet_sig;
      q_cen = core_clk_en; q_out = core_out; q_rv = rsp_valid; q_rid = rsp_id;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk); @(negedge clk);
      chk("R1 state model", fsm_state, m_state);
      chk("R10 status model", status, m_status);
      chk("R11 pulse model", viol_pulse, m_pulse);
      chk("R10 flag model", viol_flag, m_status != 0);
    end
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = 16'(d); step(1); cfg_we = 0;
  endtask
  task automatic commit(); cfg_commit = 1; step(1); cfg_commit = 0; endtask
  task automatic clear(int m); clr_we = 1; clr_data = 5'(m); step(1); clr_we = 0; endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1;
    step(1);
    chk("R3 reset status", status, 0); chk("R3 reset flag", viol_flag, 0); chk("R2 reset state", fsm_state, 0);
    quiet_sig = 1; bus_valid = 1; bus_addr = 0; step(3); quiet_sig = 0; bus_valid = 0;
    chk("R3 blank before commit", status, 0);
    step(2);
    // R12 map: trans 0..7, mask 8..15, cmp 16..23, lo 24, hi 25, ctrl 26
    wr(0, 1); wr(8, 16'h00FF); wr(16, 16'h0012);
    wr(1, 2); wr(9, 16'h00FF); wr(17, 16'h0034);
    wr(2, 64);
    wr(24, 16'h1000); wr(25, 16'h1FFF); wr(26, 16'h051F);
    commit(); step(1);
    chk("R2 state after commit", fsm_state, 0);
    probe = 16'h0012; step(1); probe = 16'h0035; step(1); probe = 0; step(3);
    chk("R1 mismatch takes default", status[0], 0);
    probe = 16'hAB12; step(1); probe = 16'h7734; step(1); probe = 0; step(3);
    chk("R5 violation state flagged", status[0], 1);
    clear(31); chk("R10 clear all", status, 0);
    bus_valid = 1; bus_addr = 16'h0FFF; step(1); bus_addr = 16'h2000; step(1); bus_valid = 0; step(2);
    chk("R6 outside window", status[1], 0);
    bus_valid = 1; bus_addr = 16'h1FFF; step(1); bus_valid = 0; step(1);
    chk("R6 upper edge inclusive", status[1], 1);
    chk("R11 first pulse", viol_pulse, 1);
    quiet_sig = 1; step(1); quiet_sig = 0; step(1);
    chk("R7 quiet asserted", status[2], 1);
    chk("R11 no pulse when pending", viol_pulse, 0);
    clear(31); step(1);
    bus_valid = 1; bus_addr = 16'h1000; step(1); bus_valid = 0; step(1);
    chk("R6 lower edge inclusive", status[1], 1);
    clear(31); step(1);
    core_out = 8'h11; step(2); chk("R8 change while enabled", status[3], 0);
    core_clk_en = 0; step(2); chk("R8 steady while gated", status[3], 0);
    core_out = 8'h22; step(1); core_clk_en = 1; step(1);
    chk("R8 change while gated", status[3], 1);
    rsp_valid = 1; rsp_id = 5; step(2); chk("R9 own id", status[4], 0);
    rsp_id = 3; step(1); rsp_valid = 0; step(1);
    chk("R9 foreign id", status[4], 1);
    clear(31); step(1);
    quiet_sig = 1; step(2); clear(4);
    chk("R10 hit wins over clear", status[2], 1);
    quiet_sig = 0; step(2); clear(4);
    chk("R10 partial clear", status, 0);
    wr(26, 0);
    quiet_sig = 1; step(1); quiet_sig = 0; step(1);
    chk("R4 shadow write not active", status[2], 1);
    clear(31);
    probe = 16'h0012; step(2);
    chk("R1 first step advanced", fsm_state, 1);
    probe = 0; commit();
    chk("R2 commit resets state", fsm_state, 0);
    quiet_sig = 1; step(1); quiet_sig = 0; step(2);
    chk("R4 committed disable active", status, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule